// File: doc/BRIEF.md
# Maskable Peripheral Event Interrupt Hub

This block gathers six peripheral event sources into one sticky pending register and drives one interrupt request line toward the processor. Each source has an enable bit in a mask register. Software reads the pending register to find out which events occurred. It clears the ones it has handled by writing ones to a clear location. The interrupt line stays high while any pending bit is also enabled.

Two of the sources are qualified inside the block. The first is the serial bus clock monitor. It raises its event once the clock line has been seen low for a fixed number of consecutive samples after it was seen high. The second is the vertical event. A vertical sync pulse raises it every time. A lasting no-sync condition raises it only once, and the guard re-arms only after sync returns. The other sources are one-cycle strobes from other logic.

Top module: `evt_irq_hub`

## Requirements
- R1: Pending bit positions are: bit 0 serial clock held low, bit 1 conversion done (`ev_adc_done`), bit 2 buffer empty (`ev_buf_empty`), bit 3 safe-area (`ev_soa`), bit 4 vertical event, bit 5 parabola (`ev_para`). A source that is high at a clock edge sets its bit, and the bit reads as set from the next cycle on.
- R2: The mask register is at address 1. It is readable and writable, and bits 5:0 use the pending bit positions. Bits 7:6 read as 0.
- R3: A pending bit is captured whether or not its mask bit is set.
- R4: A write to address 2 clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. Reads of address 2 or 3 return 0.
- R5: The pending register at address 0 is read-only: a write there changes nothing. Its bits 7:6 read as 0.
- R6: When a source event and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: `irq` is high exactly when the bitwise AND of pending and mask is nonzero.
- R8: Bit 0 is set when `scl_in` has been sampled low on 16 consecutive edges following an edge where it was sampled high. It is not yet set after the 15th low sample.
- R9: A low period shorter than 16 samples raises no bit 0 event. A single low period raises bit 0 at most once, however long it lasts.
- R10: Each cycle in which `vs_pulse` is high sets bit 4.
- R11: `vs_absent` raises bit 4 once when it is seen high. While it stays high it raises bit 4 no more. It raises bit 4 again only after it has been low and then goes high again.
- R12: After a synchronous reset, pending and mask are 0 and `irq` is low. The serial clock monitor needs a high sample before it can count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 clear |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ev_adc_done | input | 1 | Conversion-done strobe |
| ev_buf_empty | input | 1 | Output buffer empty strobe |
| ev_soa | input | 1 | Safe operating area strobe |
| ev_para | input | 1 | Parabola timer strobe |
| vs_pulse | input | 1 | Vertical sync pulse strobe |
| vs_absent | input | 1 | Level, high while vertical sync is missing |
| scl_in | input | 1 | Serial bus clock line as sampled |
| irq | output | 1 | Combined interrupt request |

## Verification
A table of mask, event and clear patterns checks the main aggregation. The patterns include a fully masked set of events, which tells capture apart from gating. Some rows enable only a source that did not fire, which tells the AND from a plain OR of the pending bits. Partial clears show that clear writes act bit by bit. Directed cases cover the rest. A clear and an event in the same cycle show that the event takes priority. Low periods of 15 and 16 samples on the serial clock mark the qualification threshold exactly, and a long low period shows that the event is raised only once. A sustained no-sync condition is held high, then released and raised again, which separates the once-only guard from a level-triggered event.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NUM_SRC = 6;
    localparam int REG_W   = 8;

    typedef enum logic [1:0] {
        ADR_PEND  = 2'd0,
        ADR_MASK  = 2'd1,
        ADR_CLEAR = 2'd2,
        ADR_NONE  = 2'd3
    } reg_sel_e;

    // Packed so that the member order gives the pending bit positions.
    typedef struct packed {
        logic para;
        logic vevt;
        logic soa;
        logic bufe;
        logic adc;
        logic sclk;
    } src_vec_t;

    function automatic logic [REG_W-1:0] widen(input src_vec_t v);
        return {{(REG_W-NUM_SRC){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sclk_low_det.sv
module sclk_low_det #(
    parameter int LOW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    output logic hit
);
    localparam int CW = $clog2(LOW_CYCLES) + 1;
    localparam logic [CW-1:0] LAST = CW'(LOW_CYCLES - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;

    assign hit = armed_q & ~scl_in & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (scl_in) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (armed_q) begin
            if (hit) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vsync_oneshot.sv
module vsync_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic vs_pulse,
    input  logic vs_absent,
    output logic hit
);
    logic fired_q;

    assign hit = vs_pulse | (vs_absent & ~fired_q);

    always_ff @(posedge clk) begin
        if (rst)
            fired_q <= 1'b0;
        else
            fired_q <= vs_absent;
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  src_vec_t         src,
    output logic [REG_W-1:0] reg_rdata,
    output src_vec_t         pend_o,
    output src_vec_t         mask_o,
    output logic             irq
);
    src_vec_t pend_q, mask_q, clr_v;
    reg_sel_e sel;

    assign sel   = reg_sel_e'(reg_addr);
    assign clr_v = (reg_wr && sel == ADR_CLEAR) ? src_vec_t'(reg_wdata[NUM_SRC-1:0]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | src;
            if (reg_wr && sel == ADR_MASK)
                mask_q <= src_vec_t'(reg_wdata[NUM_SRC-1:0]);
        end
    end

    always_comb begin
        case (sel)
            ADR_PEND: reg_rdata = widen(pend_q);
            ADR_MASK: reg_rdata = widen(mask_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq    = |(pend_q & mask_q);
    assign pend_o = pend_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int LOW_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_adc_done,
    input  logic       ev_buf_empty,
    input  logic       ev_soa,
    input  logic       ev_para,
    input  logic       vs_pulse,
    input  logic       vs_absent,
    input  logic       scl_in,
    output logic       irq
);
    logic     scl_hit;
    logic     v_hit;
    src_vec_t src;
    src_vec_t pend_q;
    src_vec_t mask_q;

    sclk_low_det #(.LOW_CYCLES(LOW_CYCLES)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .hit    (scl_hit)
    );

    vsync_oneshot u_vs (
        .clk       (clk),
        .rst       (rst),
        .vs_pulse  (vs_pulse),
        .vs_absent (vs_absent),
        .hit       (v_hit)
    );

    always_comb begin
        src      = '0;
        src.sclk = scl_hit;
        src.adc  = ev_adc_done;
        src.bufe = ev_buf_empty;
        src.soa  = ev_soa;
        src.vevt = v_hit;
        src.para = ev_para;
    end

    irq_pending u_pend (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .src       (src),
        .reg_rdata (reg_rdata),
        .pend_o    (pend_q),
        .mask_o    (mask_q),
        .irq       (irq)
    );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ev_adc_done,
    input logic       vs_pulse,
    input logic       vs_absent,
    input logic       scl_in,
    input logic       scl_hit,
    input logic       v_hit,
    input logic [5:0] pend_q,
    input logic [5:0] mask_q,
    input logic       irq
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == 2'd2);

    // R6: the conversion event is kept even under a clear of its bit
    assert_adc_sticks_R6: assert property (@(posedge clk) disable iff (rst)
        ev_adc_done |=> pend_q[1]);

    // R4: pending bits persist when no clear write happens
    assert_no_lost_bit_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R7: a cleared mask keeps the request low
    assert_mask_gates_R7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 6'd0) |-> !irq);

    // R11: no repeated vertical event while sync stays absent
    assert_vs_once_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && vs_absent && $past(vs_absent) && !vs_pulse) |-> !v_hit);

    // R8: the serial clock event only comes in a low stretch
    assert_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
        (scl_hit && !$past(rst)) |-> (!scl_in && !$past(scl_in)));

    // R5: upper read bits of the pending register stay zero
    assert_pend_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (reg_rdata[7:6] == 2'b00));

    // R12: the pending register comes out of reset empty
    assert_reset_clean_R12: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == 6'd0 && mask_q == 6'd0));
endmodule

bind evt_irq_hub evt_irq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ev_adc_done (ev_adc_done),
    .vs_pulse    (vs_pulse),
    .vs_absent   (vs_absent),
    .scl_in      (scl_in),
    .scl_hit     (scl_hit),
    .v_hit       (v_hit),
    .pend_q      (pend_q),
    .mask_q      (mask_q),
    .irq         (irq)
);

// File: tb/evt_irq_hub_tb.sv
module evt_irq_hub_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ev_adc_done = 1'b0, ev_buf_empty = 1'b0, ev_soa = 1'b0, ev_para = 1'b0;
    logic       vs_pulse = 1'b0, vs_absent = 1'b0, scl_in = 1'b1;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_irq_hub dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_adc_done(ev_adc_done), .ev_buf_empty(ev_buf_empty),
        .ev_soa(ev_soa), .ev_para(ev_para), .vs_pulse(vs_pulse),
        .vs_absent(vs_absent), .scl_in(scl_in), .irq(irq)
    );

    // fields: mask, events (bits 1..5), clear
    localparam logic [17:0] VEC [8] = '{
        {6'h3E, 6'h02, 6'h00},
        {6'h00, 6'h3E, 6'h00},
        {6'h20, 6'h04, 6'h00},
        {6'h20, 6'h20, 6'h00},
        {6'h08, 6'h0A, 6'h08},
        {6'h10, 6'h18, 6'h00},
        {6'h3F, 6'h3E, 6'h3E},
        {6'h02, 6'h12, 6'h10}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_ev(input logic [5:0] v);
        @(negedge clk);
        ev_adc_done = v[1]; ev_buf_empty = v[2]; ev_soa = v[3];
        vs_pulse = v[4]; ev_para = v[5];
        @(negedge clk);
        {ev_adc_done, ev_buf_empty, ev_soa, vs_pulse, ev_para} = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        rd(2'd0, r); check("R12 pend", r, 8'h00);
        rd(2'd1, r); check("R12 mask", r, 8'h00);
        check("R12 irq", {7'd0, irq}, 8'h00);

        // table walk: R1 R3 R4 R7
        for (int i = 0; i < 8; i++) begin
            logic [5:0] m, e, c, ex;
            {m, e, c} = VEC[i];
            ex = e & ~c;
            wr(2'd2, 8'h3F);
            wr(2'd1, {2'b00, m});
            pulse_ev(e);
            if (c != 6'd0) wr(2'd2, {2'b00, c});
            @(negedge clk);
            rd(2'd0, r); check("R1 R3 R4 pend", r, {2'b00, ex});
            rd(2'd1, r); check("R2 mask", r, {2'b00, m});
            check("R7 irq", {7'd0, irq}, {7'd0, |(ex & m)});
        end

        // R2: upper mask bits read zero
        wr(2'd1, 8'hFF);
        rd(2'd1, r); check("R2 mask upper", r, 8'h3F);
        // R4: clear address reads zero, writing 0 changes nothing
        wr(2'd2, 8'h3F);
        pulse_ev(6'h06);
        wr(2'd2, 8'h00);
        rd(2'd0, r); check("R4 zero write", r, 8'h06);
        rd(2'd2, r); check("R4 clear read", r, 8'h00);
        rd(2'd3, r); check("R4 addr3 read", r, 8'h00);
        // R5: write to pending ignored
        wr(2'd0, 8'hFF);
        rd(2'd0, r); check("R5 ro pend", r, 8'h06);
        wr(2'd2, 8'h3F);
        wr(2'd0, 8'h3F);
        rd(2'd0, r); check("R5 ro pend empty", r, 8'h00);
        check("R7 irq empty", {7'd0, irq}, 8'h00);

        // R6: event and clear same cycle
        @(negedge clk);
        ev_adc_done = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h02; reg_wr = 1'b1;
        @(negedge clk);
        ev_adc_done = 1'b0; reg_wr = 1'b0;
        rd(2'd0, r); check("R6 event wins", r, 8'h02);
        check("R7 irq set", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h3F);

        // R8: 15 low samples not enough, 16th sets
        @(negedge clk); scl_in = 1'b0;
        repeat (15) @(negedge clk);
        rd(2'd0, r); check("R8 15 lows", r, 8'h00);
        @(negedge clk);
        rd(2'd0, r); check("R8 16 lows", r, 8'h01);
        // R9: only once per low period
        wr(2'd2, 8'h01);
        repeat (30) @(negedge clk);
        rd(2'd0, r); check("R9 once", r, 8'h00);
        // R9: short low period
        scl_in = 1'b1;
        @(negedge clk); scl_in = 1'b0;
        repeat (15) @(negedge clk);
        scl_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(2'd0, r); check("R9 short low", r, 8'h00);

        // R10: each vertical pulse sets bit 4
        pulse_ev(6'h10);
        rd(2'd0, r); check("R10 first", r, 8'h10);
        wr(2'd2, 8'h10);
        pulse_ev(6'h10);
        rd(2'd0, r); check("R10 second", r, 8'h10);
        wr(2'd2, 8'h10);

        // R11: absent sync once only, re-arms after drop
        @(negedge clk); vs_absent = 1'b1;
        @(negedge clk);
        rd(2'd0, r); check("R11 first", r, 8'h10);
        wr(2'd2, 8'h10);
        repeat (10) @(negedge clk);
        rd(2'd0, r); check("R11 held", r, 8'h00);
        vs_absent = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'd0, r); check("R11 released", r, 8'h00);
        vs_absent = 1'b1;
        @(negedge clk);
        rd(2'd0, r); check("R11 rearmed", r, 8'h10);
        vs_absent = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule